// File: doc/BRIEF.md
# Gated Clock Frequency Meter

This block measures how fast one clock out of a bank of up to 64 candidate clocks is running. Software selects a source and a gate length in microseconds, then starts a measurement. For the length of the gate the block counts rising edges of the chosen clock. The gate is timed by a microsecond tick that a prescaler derives from the reference clock. When the gate closes, the edge count is left in a result register. Software turns the count into a frequency in MHz by dividing it by the gate length and rounding to nearest.

Access is through a plain 32-bit register port, with a write strobe and a combinational read mux. The control word sits at byte offset 4 and the result at byte offset 12. Offsets 0 and 8 read as zero. The normal sequence has four steps. First write zero to control. Then write the source, the gate length minus one, source enable and start together. Then poll the busy flag until it reads zero. Last, write control again with start cleared and the other fields unchanged.

The selected clock passes through a two-flop synchronizer and a rising-edge detector in the reference domain. It must therefore run slower than half the reference rate. The selection should be written about three cycles before the start write, so that the synchronizer has settled and the count is exact.

Top module: `gated_freq_meter`

## Requirements
- R1: After reset, control (offset 4) and result (offset 12) both read 0 and the busy flag is 0.
- R2: A measurement starts only on a control write that sets start (bit 16) and source enable (bit 19) while the stored start bit is 0. Any other control write never raises busy and leaves the result unchanged.
- R3: Busy (control bit 31) reads 1 from the start write until exactly (gate field + 1) × REF_PER_US reference cycles later. The gate field is bits 15:0. A gate field of 0 gives a 1 µs window.
- R4: When busy falls, result bits 15:0 equal the number of rising edges of clkBank[source] seen during the window. The source is control bits 25:20.
- R5: The result saturates at 0xFFFF rather than wrapping when more edges arrive.
- R6: The result clears to 0 on a measurement start. It then holds its value after busy falls and after start is cleared, until the next start.
- R7: Control reads back with source at 25:20, enable at 19, start at 16, gate at 15:0 and busy at 31, and zeros elsewhere. Offsets 0 and 8 read 0, and writes to them change no register.
- R8: A control write that clears start or source enable while busy ends the measurement at once. Busy reads 0 on the next read, and the partial count is frozen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| refClk | input | 1 | Reference clock; all logic runs on it |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe, taken on the rising edge of refClk |
| regAddr | input | ADDR_W | Byte address of the register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data, combinational from regAddr |
| clkBank | input | NUM_CLKS | Candidate clocks to be measured |

## Verification
Reads are combinational, so a write's effect is visible in the half cycle after the edge that takes it. The bench samples there to see busy rise and the result clear. Busy must still read 1 at W−1 cycles after the start edge and must read 0 at W cycles, where W = (gate+1) × REF_PER_US. The bench reads at both points, so a window that is one cycle long or short is caught. The measured clocks are derived from the reference clock and have periods that divide W. This makes the expected count exactly W divided by the period, whatever the phase. The abort, ignored-write and saturation cases are read back on the cycle after the write and again many cycles later.

// File: rtl/fm_pkg.sv
package fm_pkg;
  localparam int CNT_W     = 16;
  localparam int DUR_W     = 16;
  localparam int SEL_W     = 6;
  localparam int BUSY_BIT  = 31;
  localparam int SEL_LSB   = 20;
  localparam int MUXEN_BIT = 19;
  localparam int MEAS_BIT  = 16;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             muxEn;
    logic             measure;
    logic [DUR_W-1:0] dur;
  } fm_ctrl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearCnt;
    logic countEn;
  } fm_strobe_t;

  typedef enum logic {ST_IDLE, ST_GATE} fm_state_t;
endpackage

// File: rtl/fm_tick_gen.sv
module fm_tick_gen #(
  parameter int DIV = 8
) (
  input  logic refClk,
  input  logic rstN,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] divCnt;

  assign tick = (divCnt == LAST);

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (restart) divCnt <= '0;
    else if (tick)    divCnt <= '0;
    else              divCnt <= divCnt + 1'b1;
  end
endmodule

// File: rtl/fm_ctrl.sv
module fm_ctrl
  import fm_pkg::*;
#(
  parameter int REF_PER_US = 8
) (
  input  logic             refClk,
  input  logic             rstN,
  input  logic             ctrlWr,
  input  logic [31:0]      wdata,
  output fm_ctrl_t         ctrlQ,
  output logic             busy,
  output logic [DUR_W-1:0] gateDur,
  output fm_strobe_t       strobe
);
  fm_ctrl_t         wrCtrl;
  fm_state_t        state;
  logic [DUR_W-1:0] winCnt;
  logic             tick;
  logic             startHit;
  logic             abortHit;
  logic             unusedWdata;

  assign wrCtrl.sel     = wdata[SEL_LSB +: SEL_W];
  assign wrCtrl.muxEn   = wdata[MUXEN_BIT];
  assign wrCtrl.measure = wdata[MEAS_BIT];
  assign wrCtrl.dur     = wdata[DUR_W-1:0];
  assign unusedWdata    = ^{wdata[31:26], wdata[18:17]};

  assign startHit = ctrlWr && wrCtrl.measure && wrCtrl.muxEn && !ctrlQ.measure;
  assign abortHit = ctrlWr && (state == ST_GATE) && !(wrCtrl.measure && wrCtrl.muxEn);

  fm_tick_gen #(.DIV(REF_PER_US)) uTick (
    .refClk (refClk),
    .rstN   (rstN),
    .restart(startHit),
    .tick   (tick)
  );

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)       ctrlQ <= '0;
    else if (ctrlWr) ctrlQ <= wrCtrl;
  end

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      winCnt  <= '0;
      gateDur <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (startHit) begin
            state   <= ST_GATE;
            winCnt  <= '0;
            gateDur <= wrCtrl.dur;
          end
        end
        ST_GATE: begin
          if (abortHit) begin
            state <= ST_IDLE;
          end else if (tick) begin
            if (winCnt == gateDur) state  <= ST_IDLE;
            else                   winCnt <= winCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign busy            = (state == ST_GATE);
  assign strobe.clearCnt = startHit;
  assign strobe.countEn  = busy;
endmodule

// File: rtl/fm_edge_sync.sv
module fm_edge_sync (
  input  logic refClk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic meta, syncQ, prevQ;

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN) begin
      meta  <= 1'b0;
      syncQ <= 1'b0;
      prevQ <= 1'b0;
    end else begin
      meta  <= din;
      syncQ <= meta;
      prevQ <= syncQ;
    end
  end

  assign rise = syncQ && !prevQ;
endmodule

// File: rtl/fm_datapath.sv
module fm_datapath
  import fm_pkg::*;
#(
  parameter int NUM_CLKS = 64
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic [NUM_CLKS-1:0] clkBank,
  input  logic [SEL_W-1:0]    sel,
  input  logic                muxEn,
  input  fm_strobe_t          strobe,
  output logic [CNT_W-1:0]    resultQ
);
  localparam int IDX_W = (NUM_CLKS > 1) ? $clog2(NUM_CLKS) : 1;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [IDX_W-1:0] selIdx;
  logic             selValid;
  logic             srcBit;
  logic             rise;

  assign selIdx   = sel[IDX_W-1:0];
  assign selValid = (int'(sel) < NUM_CLKS);
  assign srcBit   = muxEn && selValid && clkBank[selIdx];

  fm_edge_sync uSync (
    .refClk(refClk),
    .rstN  (rstN),
    .din   (srcBit),
    .rise  (rise)
  );

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)                                          resultQ <= '0;
    else if (strobe.clearCnt)                           resultQ <= '0;
    else if (strobe.countEn && rise && resultQ != CNT_MAX) resultQ <= resultQ + 1'b1;
  end
endmodule

// File: rtl/gated_freq_meter.sv
module gated_freq_meter
  import fm_pkg::*;
#(
  parameter int NUM_CLKS   = 64,
  parameter int REF_PER_US = 8,
  parameter int ADDR_W     = 4
) (
  input  logic                refClk,
  input  logic                rstN,
  input  logic                regWr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [31:0]         regWdata,
  output logic [31:0]         regRdata,
  input  logic [NUM_CLKS-1:0] clkBank
);
  localparam logic [ADDR_W-1:0] CTRL_OFF = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] RES_OFF  = ADDR_W'(12);

  fm_ctrl_t         ctrlQ;
  fm_strobe_t       strobe;
  logic             busy;
  logic [DUR_W-1:0] gateDur;
  logic [CNT_W-1:0] resultQ;
  logic             ctrlWr;

  assign ctrlWr = regWr && (regAddr == CTRL_OFF);

  fm_ctrl #(.REF_PER_US(REF_PER_US)) uCtrl (
    .refClk (refClk),
    .rstN   (rstN),
    .ctrlWr (ctrlWr),
    .wdata  (regWdata),
    .ctrlQ  (ctrlQ),
    .busy   (busy),
    .gateDur(gateDur),
    .strobe (strobe)
  );

  fm_datapath #(.NUM_CLKS(NUM_CLKS)) uPath (
    .refClk (refClk),
    .rstN   (rstN),
    .clkBank(clkBank),
    .sel    (ctrlQ.sel),
    .muxEn  (ctrlQ.muxEn),
    .strobe (strobe),
    .resultQ(resultQ)
  );

  always_comb begin
    regRdata = '0;
    if (regAddr == CTRL_OFF) begin
      regRdata[BUSY_BIT]              = busy;
      regRdata[SEL_LSB +: SEL_W]      = ctrlQ.sel;
      regRdata[MUXEN_BIT]             = ctrlQ.muxEn;
      regRdata[MEAS_BIT]              = ctrlQ.measure;
      regRdata[DUR_W-1:0]             = ctrlQ.dur;
    end else if (regAddr == RES_OFF) begin
      regRdata[CNT_W-1:0]             = resultQ;
    end
  end
endmodule

// File: rtl/fm_checker.sv
module fm_checker #(
  parameter int REF_PER_US = 8,
  parameter int ADDR_W     = 4
) (
  input logic              refClk,
  input logic              rstN,
  input logic              regWr,
  input logic [ADDR_W-1:0] regAddr,
  input logic [31:0]       regWdata,
  input logic [31:0]       regRdata,
  input logic              busy,
  input logic [15:0]       gateDur,
  input logic [15:0]       resultQ
);
  logic [31:0] busyLen;
  logic        startWr;

  assign startWr = regWr && (regAddr == ADDR_W'(4)) && regWdata[16] && regWdata[19];

  always_ff @(posedge refClk or negedge rstN) begin
    if (!rstN)      busyLen <= '0;
    else if (!busy) busyLen <= '0;
    else            busyLen <= busyLen + 1;
  end

  // R2: busy only rises after a start write with enable
  a_r2_start_cause: assert property (@(posedge refClk) disable iff (!rstN)
    $rose(busy) |-> $past(startWr));

  // R3: an unaborted window lasts (gate+1)*REF_PER_US cycles
  a_r3_window_len: assert property (@(posedge refClk) disable iff (!rstN)
    ($fell(busy) && !$past(regWr)) |-> busyLen == (32'(gateDur) + 1) * REF_PER_US);

  // R4: count steps by at most one per cycle while gating
  a_r4_single_step: assert property (@(posedge refClk) disable iff (!rstN)
    busy |=> (resultQ == $past(resultQ)) || (resultQ == $past(resultQ) + 16'd1));

  // R5: saturated count stays saturated
  a_r5_no_overflow: assert property (@(posedge refClk) disable iff (!rstN)
    (busy && resultQ == 16'hFFFF) |=> resultQ == 16'hFFFF);

  // R6: result holds while idle unless a start arrives
  a_r6_hold_idle: assert property (@(posedge refClk) disable iff (!rstN)
    (!busy && !startWr) |=> $stable(resultQ));

  // R7: unused slots read zero
  a_r7_empty_slots: assert property (@(posedge refClk) disable iff (!rstN)
    (regAddr == ADDR_W'(0) || regAddr == ADDR_W'(8)) |-> regRdata == 32'd0);
endmodule

bind gated_freq_meter fm_checker #(.REF_PER_US(REF_PER_US), .ADDR_W(ADDR_W)) uChk (
  .refClk  (refClk),
  .rstN    (rstN),
  .regWr   (regWr),
  .regAddr (regAddr),
  .regWdata(regWdata),
  .regRdata(regRdata),
  .busy    (busy),
  .gateDur (gateDur),
  .resultQ (resultQ)
);

// File: tb/tb_gated_freq_meter.sv
module tb_gated_freq_meter;
  localparam int NCLK = 64;
  localparam int DIV  = 2;
  localparam int NVEC = 8;

  // {sel[5:0], gate[15:0], expected count[15:0]}
  localparam logic [37:0] VEC [NVEC] = '{
    {6'd0,  16'd11, 16'd12},
    {6'd5,  16'd11, 16'd6},
    {6'd10, 16'd11, 16'd4},
    {6'd63, 16'd11, 16'd3},
    {6'd0,  16'd0,  16'd1},
    {6'd1,  16'd1,  16'd1},
    {6'd7,  16'd39, 16'd10},
    {6'd12, 16'd99, 16'd100}
  };

  logic            refClk = 1'b0;
  logic            rstN   = 1'b0;
  logic            regWr  = 1'b0;
  logic [3:0]      regAddr = '0;
  logic [31:0]     regWdata = '0;
  logic [31:0]     regRdata;
  logic [NCLK-1:0] clkBank = '0;
  int              halfCnt [NCLK];
  int              checks = 0;
  int              errors = 0;
  bit              done = 0;

  gated_freq_meter #(.NUM_CLKS(NCLK), .REF_PER_US(DIV), .ADDR_W(4)) dut (
    .refClk  (refClk),
    .rstN    (rstN),
    .regWr   (regWr),
    .regAddr (regAddr),
    .regWdata(regWdata),
    .regRdata(regRdata),
    .clkBank (clkBank)
  );

  always #4 refClk = ~refClk;

  // bank bit i toggles every (i%4)+1 cycles: period 2,4,6,8
  initial for (int i = 0; i < NCLK; i++) halfCnt[i] = 0;
  always @(negedge refClk) begin
    for (int i = 0; i < NCLK; i++) begin
      if (halfCnt[i] == (i % 4)) begin
        halfCnt[i] = 0;
        clkBank[i] = ~clkBank[i];
      end else begin
        halfCnt[i] = halfCnt[i] + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge refClk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge refClk);
    regWr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdata;
  endtask

  function automatic logic [31:0] ctrlWord(input logic [5:0] s, input logic en,
                                           input logic meas, input logic [15:0] g);
    return {1'b0, 5'b0, s, en, 2'b0, meas, g};
  endfunction

  task automatic waitCyc(input int n);
    repeat (n) @(negedge refClk);
  endtask

  initial begin
    repeat (200000) @(posedge refClk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, r, held;
    int w;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(2);

    // R1 reset state
    rd(4'd4, v);  chk("R1 ctrl after reset", v, 32'd0);
    rd(4'd12, v); chk("R1 result after reset", v, 32'd0);

    // vector loop: R3 R4 R6 R7
    for (int k = 0; k < NVEC; k++) begin
      logic [5:0]  s;
      logic [15:0] g, e;
      {s, g, e} = VEC[k];
      w = (int'(g) + 1) * DIV;
      wr(4'd4, 32'd0);
      wr(4'd4, ctrlWord(s, 1'b1, 1'b0, g));
      waitCyc(4);
      wr(4'd4, ctrlWord(s, 1'b1, 1'b1, g));
      rd(4'd4, v);  chk($sformatf("R3 busy up vec%0d", k), 32'(v[31]), 32'd1);
      rd(4'd12, v); chk($sformatf("R6 cleared at start vec%0d", k), v, 32'd0);
      waitCyc(w - 1);
      rd(4'd4, v);  chk($sformatf("R3 busy at W-1 vec%0d", k), 32'(v[31]), 32'd1);
      waitCyc(1);
      rd(4'd4, v);  chk($sformatf("R7 ctrl readback idle vec%0d", k), v, ctrlWord(s, 1'b1, 1'b1, g));
      rd(4'd12, v); chk($sformatf("R4 count vec%0d", k), v, 32'(e));
      wr(4'd4, ctrlWord(s, 1'b1, 1'b0, g));
      waitCyc(10);
      rd(4'd12, v); chk($sformatf("R6 held after clear vec%0d", k), v, 32'(e));
    end

    // R7 empty slots read zero and writes there are ignored
    rd(4'd12, held);
    wr(4'd0, 32'hFFFF_FFFF);
    wr(4'd8, 32'hFFFF_FFFF);
    rd(4'd0, v);  chk("R7 offset 0 reads zero", v, 32'd0);
    rd(4'd8, v);  chk("R7 offset 8 reads zero", v, 32'd0);
    rd(4'd4, v);  chk("R7 ctrl untouched", v, ctrlWord(6'd12, 1'b1, 1'b0, 16'd99));
    rd(4'd12, v); chk("R7 result untouched", v, held);

    // R2 start without enable is ignored
    wr(4'd4, ctrlWord(6'd0, 1'b0, 1'b1, 16'd3));
    rd(4'd4, v);  chk("R2 no busy without enable", 32'(v[31]), 32'd0);
    waitCyc(20);
    rd(4'd12, v); chk("R2 result kept without enable", v, held);
    // R2 start bit already set: no new measurement
    wr(4'd4, ctrlWord(6'd0, 1'b1, 1'b1, 16'd3));
    rd(4'd4, v);  chk("R2 no busy when start already set", 32'(v[31]), 32'd0);
    rd(4'd12, v); chk("R2 result kept when start already set", v, held);

    // R8 abort mid-window
    wr(4'd4, 32'd0);
    wr(4'd4, ctrlWord(6'd0, 1'b1, 1'b0, 16'd999));
    waitCyc(4);
    wr(4'd4, ctrlWord(6'd0, 1'b1, 1'b1, 16'd999));
    waitCyc(10);
    wr(4'd4, ctrlWord(6'd0, 1'b1, 1'b0, 16'd999));
    rd(4'd4, v);  chk("R8 busy low after abort", 32'(v[31]), 32'd0);
    rd(4'd12, r);
    chk("R8 partial count in range", 32'((r >= 32'd4) && (r <= 32'd7)), 32'd1);
    waitCyc(50);
    rd(4'd12, v); chk("R8 partial count frozen", v, r);

    // R5 saturation: 65536 edges in a 65536 us window
    wr(4'd4, 32'd0);
    wr(4'd4, ctrlWord(6'd0, 1'b1, 1'b0, 16'hFFFF));
    waitCyc(4);
    wr(4'd4, ctrlWord(6'd0, 1'b1, 1'b1, 16'hFFFF));
    waitCyc(65536 * DIV - 1);
    rd(4'd4, v);  chk("R3 busy before long window end", 32'(v[31]), 32'd1);
    waitCyc(1);
    rd(4'd4, v);  chk("R3 busy low after long window", 32'(v[31]), 32'd0);
    rd(4'd12, v); chk("R5 saturated count", v, 32'h0000_FFFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule